// File: doc/BRIEF.md
# Sensor Calibration Slope and Offset Unit

This block turns the per-sensor calibration words of an on-die temperature sensor into a linear transfer function. It then uses that function to convert between raw sensor codes and whole degrees Celsius. A calibration request supplies a 2-bit mode, an invalid flag, two base values, the sensor's two raw points and a shift amount. The unit forms the two reference points from these inputs. In two-point mode it derives the slope with a sequential divider, and in every mode it derives the offset. Slope and offset are held until the next calibration.

A conversion request runs in one of two directions. Code-to-degrees rounds half away from zero. Degrees-to-code truncates toward zero and then clamps to the legal code range. Both directions share the one signed divider, which resolves one quotient bit per clock. Every accepted request ends with a single-cycle done pulse. Requests that arrive while the unit is busy are dropped.

Top module: `cal_unit`

## Requirements
- R1: After reset, busy_o and done_o are 0, slope_o is 3200, offset_o is 0 and result_o is 0.
- R2: Mode encoding: 0 = uncalibrated, 1 = one-point, 2 = two-point, 3 = one-point shifted. Mode 1 uses point1 = p1 + (base1 << shift). Mode 3 uses point1 = (p1 + base1) << shift. Mode 0 uses point1 = 500 and point2 = 780. In modes 0, 1 and 3 the slope is set to the default 3200.
- R3: In mode 2, point1 = (p1 + base1) << shift and point2 = (p2 + base2) << shift. The slope is (point2 - point1) * 3200 / 90, as a signed division truncated toward zero.
- R4: In every mode the offset is point1 * 3200 - 30 * slope.
- R5: When invalid_i is 1 at a calibration request, mode 0 is applied whatever mode_i holds.
- R6: Code-to-degrees (conv_dir_i = 0) forms num = code * 3200 - offset. The result is 0 when num is 0. Otherwise it is (num + slope/2) / slope when num > 0 and (num - slope/2) / slope when num < 0. Every division truncates toward zero, and the result is taken to 16 bits.
- R7: Degrees-to-code (conv_dir_i = 1) gives (deg * slope + offset) / 3200, truncated toward zero and clamped to the range 0 to 1023.
- R8: A division whose divisor is zero yields a quotient of 0, so code-to-degrees with slope 0 returns 0.
- R9: An accepted request raises busy_o in the next cycle. It ends with exactly one cycle of done_o, during which busy_o is 0.
- R10: A start that arrives while busy_o is 1 is ignored. When cal_start_i and conv_start_i are high in the same cycle, the calibration runs and the conversion is dropped.
- R11: Every request completes within 52 cycles of its start.
- R12: A conversion leaves slope_o and offset_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_start_i | input | 1 | Calibration request |
| mode_i | input | 2 | Calibration mode |
| invalid_i | input | 1 | Calibration data invalid, forces mode 0 |
| base1_i | input | 10 | First base value |
| base2_i | input | 10 | Second base value |
| p1_i | input | 10 | Sensor first point |
| p2_i | input | 10 | Sensor second point |
| shift_i | input | 3 | Left shift applied to base or point sums |
| conv_start_i | input | 1 | Conversion request |
| conv_dir_i | input | 1 | 0 code-to-degrees, 1 degrees-to-code |
| conv_code_i | input | 10 | Raw code for code-to-degrees |
| conv_deg_i | input | 9 | Signed degrees for degrees-to-code |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| slope_o | output | 48 | Signed slope |
| offset_o | output | 48 | Signed offset |
| result_o | output | 16 | Signed conversion result |

## Verification
Directed calibrations cover each of the four modes with the same fuse words. This shows whether the shift applies to the base alone or to the sum, and whether the slope is derived or left at the default. The invalid flag is then raised over a two-point setting. Conversions near the zero numerator, on either side of it, expose the rounding sign. A steep two-point slope drives degrees-to-code past both code limits, and equal points give a zero slope that exercises the zero divisor. Random calibrations, including descending points that give negative slopes, each followed by random conversions in both directions, are compared against a bench model of the formulas. Overlapping and colliding starts check that requests are dropped.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  typedef enum logic [1:0] {
    CM_NONE   = 2'd0,
    CM_ONE    = 2'd1,
    CM_TWO    = 2'd2,
    CM_ONE_SH = 2'd3
  } cal_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_OFFS = 2'd2,
    ST_ZERO = 2'd3
  } cal_state_e;

  typedef enum logic [1:0] {
    JOB_SLOPE = 2'd0,
    JOB_C2D   = 2'd1,
    JOB_D2C   = 2'd2
  } cal_job_e;

  localparam int T_LO     = 30;
  localparam int T_SPAN   = 90;
  localparam int UNCAL_P1 = 500;
  localparam int UNCAL_P2 = 780;
endpackage

// File: rtl/cal_point_prep.sv
`timescale 1ns/1ps
module cal_point_prep
  import cal_pkg::*;
#(
  parameter int CAL_W   = 10,
  parameter int SHIFT_W = 3,
  parameter int ACC_W   = 48
) (
  input  logic [1:0]              mode_i,
  input  logic                    invalid_i,
  input  logic [CAL_W-1:0]        base1_i,
  input  logic [CAL_W-1:0]        base2_i,
  input  logic [CAL_W-1:0]        p1_i,
  input  logic [CAL_W-1:0]        p2_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  output logic signed [ACC_W-1:0] pt1_o,
  output logic signed [ACC_W-1:0] pt2_o,
  output logic                    two_pt_o
);
  cal_mode_e eff;
  logic signed [ACC_W-1:0] b1, b2, a1, a2;

  always_comb begin
    eff = invalid_i ? CM_NONE : cal_mode_e'(mode_i);
    b1  = ACC_W'(base1_i);
    b2  = ACC_W'(base2_i);
    a1  = ACC_W'(p1_i);
    a2  = ACC_W'(p2_i);
    pt1_o    = ACC_W'(UNCAL_P1);
    pt2_o    = ACC_W'(UNCAL_P2);
    two_pt_o = 1'b0;
    case (eff)
      CM_ONE: begin
        pt1_o = a1 + (b1 << shift_i);
        pt2_o = '0;
      end
      CM_TWO: begin
        pt1_o    = (a1 + b1) << shift_i;
        pt2_o    = (a2 + b2) << shift_i;
        two_pt_o = 1'b1;
      end
      CM_ONE_SH: begin
        pt1_o = (a1 + b1) << shift_i;
        pt2_o = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cal_conv_prep.sv
`timescale 1ns/1ps
module cal_conv_prep #(
  parameter int CODE_W = 10,
  parameter int DEG_W  = 9,
  parameter int ACC_W  = 48,
  parameter int SCALE  = 3200
) (
  input  logic                    dir_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic signed [DEG_W-1:0] deg_i,
  input  logic signed [ACC_W-1:0] slope_i,
  input  logic signed [ACC_W-1:0] offset_i,
  output logic signed [ACC_W-1:0] num_o,
  output logic signed [ACC_W-1:0] den_o,
  output logic                    zero_o
);
  localparam logic signed [ACC_W-1:0] SCALE_X = ACC_W'(SCALE);

  logic signed [ACC_W-1:0] code_x, deg_x, raw, rnd, half;

  always_comb begin
    code_x = ACC_W'(code_i);
    deg_x  = ACC_W'(deg_i);
    raw    = code_x * SCALE_X - offset_i;
    // slope/2 truncated toward zero
    rnd    = {{(ACC_W-1){1'b0}}, slope_i[ACC_W-1]};
    half   = (slope_i + rnd) >>> 1;
    if (dir_i) begin
      num_o  = deg_x * slope_i + offset_i;
      den_o  = SCALE_X;
      zero_o = 1'b0;
    end else begin
      zero_o = (raw == 0);
      num_o  = (raw > 0) ? raw + half : raw - half;
      den_o  = slope_i;
    end
  end
endmodule

// File: rtl/cal_div.sv
`timescale 1ns/1ps
module cal_div #(
  parameter int W = 48
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] num_i,
  input  logic signed [W-1:0] den_i,
  output logic                busy_o,
  output logic                done_o,
  output logic signed [W-1:0] quo_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     rem_q, acc_q, den_q;
  logic             neg_q, dz_q, busy_q, done_q;

  logic [W-1:0] n_mag, d_mag, rem_n, acc_n;
  logic [W:0]   trial;
  logic         ge;

  always_comb begin
    n_mag = num_i[W-1] ? W'(-num_i) : W'(num_i);
    d_mag = den_i[W-1] ? W'(-den_i) : W'(den_i);
    trial = {rem_q, acc_q[W-1]};
    ge    = trial >= {1'b0, den_q};
    rem_n = ge ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
    acc_n = {acc_q[W-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      den_q  <= '0;
      neg_q  <= 1'b0;
      dz_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(W);
      rem_q  <= '0;
      acc_q  <= n_mag;
      den_q  <= d_mag;
      neg_q  <= num_i[W-1] ^ den_i[W-1];
      dz_q   <= (den_i == '0);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= rem_n;
      acc_q <= acc_n;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = dz_q ? '0 : (neg_q ? W'(-acc_q) : W'(acc_q));
endmodule

// File: rtl/cal_unit.sv
`timescale 1ns/1ps
module cal_unit
  import cal_pkg::*;
#(
  parameter int CAL_W     = 10,
  parameter int SHIFT_W   = 3,
  parameter int CODE_W    = 10,
  parameter int DEG_W     = 9,
  parameter int RES_W     = 16,
  parameter int ACC_W     = 48,
  parameter int SCALE     = 3200,
  parameter int SLOPE_DEF = 3200,
  parameter int CODE_MIN  = 0,
  parameter int CODE_MAX  = 1023
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cal_start_i,
  input  logic [1:0]              mode_i,
  input  logic                    invalid_i,
  input  logic [CAL_W-1:0]        base1_i,
  input  logic [CAL_W-1:0]        base2_i,
  input  logic [CAL_W-1:0]        p1_i,
  input  logic [CAL_W-1:0]        p2_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic                    conv_start_i,
  input  logic                    conv_dir_i,
  input  logic [CODE_W-1:0]       conv_code_i,
  input  logic signed [DEG_W-1:0] conv_deg_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] slope_o,
  output logic signed [ACC_W-1:0] offset_o,
  output logic signed [RES_W-1:0] result_o
);
  localparam logic signed [ACC_W-1:0] SCALE_X = ACC_W'(SCALE);
  localparam logic signed [ACC_W-1:0] SDEF_X  = ACC_W'(SLOPE_DEF);
  localparam logic signed [ACC_W-1:0] TLO_X   = ACC_W'(T_LO);
  localparam logic signed [ACC_W-1:0] SPAN_X  = ACC_W'(T_SPAN);
  localparam logic signed [ACC_W-1:0] CMIN_X  = ACC_W'(CODE_MIN);
  localparam logic signed [ACC_W-1:0] CMAX_X  = ACC_W'(CODE_MAX);

  cal_state_e st_q;
  cal_job_e   job_q;
  logic signed [ACC_W-1:0] pt1_q, slope_q, offset_q;
  logic signed [RES_W-1:0] result_q;
  logic                    done_q;

  logic signed [ACC_W-1:0] pt1, pt2, cnum, cden, dnum, dden, quo, clamped;
  logic two_pt, czero, div_start, div_busy, div_done;

  cal_point_prep #(.CAL_W(CAL_W), .SHIFT_W(SHIFT_W), .ACC_W(ACC_W)) u_prep (
    .mode_i   (mode_i),
    .invalid_i(invalid_i),
    .base1_i  (base1_i),
    .base2_i  (base2_i),
    .p1_i     (p1_i),
    .p2_i     (p2_i),
    .shift_i  (shift_i),
    .pt1_o    (pt1),
    .pt2_o    (pt2),
    .two_pt_o (two_pt)
  );

  cal_conv_prep #(.CODE_W(CODE_W), .DEG_W(DEG_W), .ACC_W(ACC_W), .SCALE(SCALE)) u_conv (
    .dir_i   (conv_dir_i),
    .code_i  (conv_code_i),
    .deg_i   (conv_deg_i),
    .slope_i (slope_q),
    .offset_i(offset_q),
    .num_o   (cnum),
    .den_o   (cden),
    .zero_o  (czero)
  );

  cal_div #(.W(ACC_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (dnum),
    .den_i  (dden),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (quo)
  );

  // calibration wins over a same-cycle conversion
  always_comb begin
    div_start = 1'b0;
    dnum      = cnum;
    dden      = cden;
    if (st_q == ST_IDLE) begin
      if (cal_start_i) begin
        div_start = two_pt;
        dnum      = (pt2 - pt1) * SCALE_X;
        dden      = SPAN_X;
      end else if (conv_start_i) begin
        div_start = !czero;
      end
    end
  end

  always_comb begin
    clamped = quo;
    if (quo < CMIN_X) clamped = CMIN_X;
    else if (quo > CMAX_X) clamped = CMAX_X;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      job_q    <= JOB_SLOPE;
      pt1_q    <= '0;
      slope_q  <= SDEF_X;
      offset_q <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cal_start_i) begin
            pt1_q <= pt1;
            job_q <= JOB_SLOPE;
            if (two_pt) begin
              st_q <= ST_DIV;
            end else begin
              slope_q <= SDEF_X;
              st_q    <= ST_OFFS;
            end
          end else if (conv_start_i) begin
            job_q <= conv_dir_i ? JOB_D2C : JOB_C2D;
            st_q  <= czero ? ST_ZERO : ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done && !div_busy) begin
            case (job_q)
              JOB_SLOPE: begin
                slope_q <= quo;
                st_q    <= ST_OFFS;
              end
              JOB_D2C: begin
                result_q <= RES_W'(clamped);
                done_q   <= 1'b1;
                st_q     <= ST_IDLE;
              end
              default: begin
                result_q <= RES_W'(quo);
                done_q   <= 1'b1;
                st_q     <= ST_IDLE;
              end
            endcase
          end
        end
        ST_OFFS: begin
          offset_q <= pt1_q * SCALE_X - TLO_X * slope_q;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: begin
          result_q <= '0;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign slope_o  = slope_q;
  assign offset_o = offset_q;
  assign result_o = result_q;
endmodule

// File: rtl/cal_unit_chk.sv
`timescale 1ns/1ps
module cal_unit_chk #(
  parameter int ACC_W    = 48,
  parameter int RES_W    = 16,
  parameter int CODE_MIN = 0,
  parameter int CODE_MAX = 1023
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cal_start_i,
  input logic                    conv_start_i,
  input logic                    conv_dir_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] slope_o,
  input logic signed [ACC_W-1:0] offset_o,
  input logic signed [RES_W-1:0] result_o
);
  localparam int LIMIT = ACC_W + 4;
  localparam int RUN_W = $clog2(LIMIT + 2);
  localparam logic signed [RES_W-1:0] MIN_R = RES_W'(CODE_MIN);
  localparam logic signed [RES_W-1:0] MAX_R = RES_W'(CODE_MAX);

  logic cal_pend_q, d2c_q;
  logic [RUN_W-1:0] run_q;
  logic acc_cal, acc_conv;

  assign acc_cal  = !busy_o && cal_start_i;
  assign acc_conv = !busy_o && !cal_start_i && conv_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_pend_q <= 1'b0;
      d2c_q      <= 1'b0;
      run_q      <= '0;
    end else begin
      if (acc_cal) cal_pend_q <= 1'b1;
      else if (done_o) cal_pend_q <= 1'b0;
      if (acc_cal) d2c_q <= 1'b0;
      else if (acc_conv) d2c_q <= conv_dir_i;
      if (!busy_o) run_q <= '0;
      else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_cal || acc_conv) |=> busy_o); // R9
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && d2c_q) |-> (result_o >= MIN_R && result_o <= MAX_R)); // R7
  AST_CAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cal_pend_q && !acc_cal) |=> ($stable(slope_o) && $stable(offset_o))); // R12
  AST_BOUNDED_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q <= RUN_W'(LIMIT))); // R11
endmodule

bind cal_unit cal_unit_chk #(
  .ACC_W   (ACC_W),
  .RES_W   (RES_W),
  .CODE_MIN(CODE_MIN),
  .CODE_MAX(CODE_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cal_start_i (cal_start_i),
  .conv_start_i(conv_start_i),
  .conv_dir_i  (conv_dir_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .slope_o     (slope_o),
  .offset_o    (offset_o),
  .result_o    (result_o)
);

// File: tb/cal_unit_bench.sv
`timescale 1ns/1ps
module cal_unit_bench;
  localparam int ACC_W = 48;
  localparam int RES_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, cal_start, invalid, conv_start, conv_dir;
  logic [1:0] mode;
  logic [9:0] base1, base2, p1, p2, code;
  logic [2:0] shift;
  logic signed [8:0] deg;
  logic busy, done;
  logic signed [ACC_W-1:0] slope, offset;
  logic signed [RES_W-1:0] result;

  cal_unit u_cal_unit (
    .clk_i(clk), .rst_ni(rst_ni), .cal_start_i(cal_start), .mode_i(mode),
    .invalid_i(invalid), .base1_i(base1), .base2_i(base2), .p1_i(p1), .p2_i(p2),
    .shift_i(shift), .conv_start_i(conv_start), .conv_dir_i(conv_dir),
    .conv_code_i(code), .conv_deg_i(deg), .busy_o(busy), .done_o(done),
    .slope_o(slope), .offset_o(offset), .result_o(result)
  );

  int n_chk = 0, n_fail = 0, done_cnt = 0;
  longint m_slope = 3200, m_off = 0;

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_cal(int md, bit inv, longint b1, longint b2,
                                    longint a1, longint a2, int sh);
    longint pt1, pt2;
    int eff;
    eff = inv ? 0 : md;
    m_slope = 3200;
    case (eff)
      1: pt1 = a1 + (b1 << sh);
      2: begin
        pt1 = (a1 + b1) << sh;
        pt2 = (a2 + b2) << sh;
        m_slope = ((pt2 - pt1) * 3200) / 90;
      end
      3: pt1 = (a1 + b1) << sh;
      default: pt1 = 500;
    endcase
    m_off = pt1 * 3200 - 30 * m_slope;
  endfunction

  function automatic longint model_c2d(longint c);
    longint num;
    num = c * 3200 - m_off;
    if (num == 0 || m_slope == 0) return 0;
    if (num > 0) return (num + m_slope / 2) / m_slope;
    return (num - m_slope / 2) / m_slope;
  endfunction

  function automatic longint model_d2c(longint d);
    longint q;
    q = (d * m_slope + m_off) / 3200;
    if (q < 0) q = 0;
    if (q > 1023) q = 1023;
    return q;
  endfunction

  task automatic wait_done(input string tag);
    int cyc;
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc <= ACC_W + 4, {tag, " R11 latency"}, cyc, ACC_W + 4);
  endtask

  task automatic run_cal(input int md, input bit inv, input int b1, input int b2,
                         input int a1, input int a2, input int sh, input string tag);
    mode = 2'(md); invalid = inv; base1 = 10'(b1); base2 = 10'(b2);
    p1 = 10'(a1); p2 = 10'(a2); shift = 3'(sh);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    wait_done(tag);
    model_cal(md, inv, b1, b2, a1, a2, sh);
    chk(slope == m_slope, {tag, " slope"}, longint'(slope), m_slope);
    chk(offset == m_off, {tag, " offset"}, longint'(offset), m_off);
    @(negedge clk);
    chk(!done, "R9 done single cycle", longint'(done), 0);
  endtask

  task automatic run_conv(input bit dir, input int c, input int d, input string tag);
    longint e;
    logic [RES_W-1:0] e16;
    conv_dir = dir; code = 10'(c); deg = 9'(d);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    wait_done(tag);
    e = dir ? model_d2c(d) : model_c2d(c);
    e16 = e[RES_W-1:0];
    chk(result == e16, tag, longint'(result), longint'($signed(e16)));
    @(negedge clk);
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [RES_W-1:0] keep;
    int d0;
    longint s_keep, o_keep;
    void'($urandom(32'd7321));
    rst_ni = 1'b0; cal_start = 0; conv_start = 0; invalid = 0; conv_dir = 0;
    mode = 0; base1 = 0; base2 = 0; p1 = 0; p2 = 0; shift = 0; code = 0; deg = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 busy/done", longint'({busy, done}), 0);
    chk(slope == 3200, "R1 slope", longint'(slope), 3200);
    chk(offset == 0, "R1 offset", longint'(offset), 0);
    chk(result == 0, "R1 result", longint'(result), 0);

    run_cal(1, 0, 5, 9, 20, 40, 2, "R2 one-point R4");
    run_cal(3, 0, 5, 9, 20, 40, 2, "R2 one-point shifted R4");
    run_cal(2, 0, 5, 9, 20, 40, 2, "R3 two-point R4");
    run_cal(2, 1, 5, 9, 20, 40, 2, "R5 invalid forces uncalibrated");
    run_cal(0, 0, 5, 9, 20, 40, 2, "R2 uncalibrated");

    // uncalibrated: offset = 470 * 3200
    run_conv(0, 470, 0, "R6 zero numerator");
    run_conv(0, 471, 0, "R6 positive round");
    run_conv(0, 469, 0, "R6 negative round");
    run_conv(1, 0, 255, "R7 deg to code");
    run_conv(1, 0, -256, "R7 deg to code low");

    s_keep = longint'(slope); o_keep = longint'(offset);
    run_conv(0, 900, 0, "R6 c2d");
    run_conv(1, 0, 40, "R7 d2c");
    chk(slope == s_keep, "R12 slope kept", longint'(slope), s_keep);
    chk(offset == o_keep, "R12 offset kept", longint'(offset), o_keep);

    run_cal(2, 0, 0, 0, 0, 100, 3, "R3 steep");
    run_conv(1, 0, 255, "R7 clamp high");
    run_conv(1, 0, -100, "R7 clamp low");

    run_cal(2, 0, 7, 7, 60, 60, 1, "R3 zero slope");
    run_conv(0, 3, 0, "R8 zero divisor");

    // R10: conversion during a busy calibration is dropped
    keep = result;
    d0 = done_cnt;
    mode = 2; invalid = 0; base1 = 10; base2 = 20; p1 = 100; p2 = 300; shift = 1;
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    @(negedge clk);
    conv_dir = 1'b0; code = 10'd512; conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    wait_done("R10 busy");
    repeat (60) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10 busy start ignored", done_cnt - d0, 1);
    chk(result == $signed(keep), "R10 result untouched", longint'(result), longint'($signed(keep)));
    model_cal(2, 0, 10, 20, 100, 300, 1);
    chk(slope == m_slope, "R10 slope", longint'(slope), m_slope);

    // R10: simultaneous starts, calibration wins
    d0 = done_cnt;
    mode = 0; conv_dir = 1'b0; code = 10'd600;
    cal_start = 1'b1; conv_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0; conv_start = 1'b0;
    wait_done("R10 collide");
    repeat (60) @(negedge clk);
    model_cal(0, 0, 0, 0, 0, 0, 0);
    chk(done_cnt - d0 == 1, "R10 collide single done", done_cnt - d0, 1);
    chk(result == $signed(keep), "R10 collide result", longint'(result), longint'($signed(keep)));
    chk(offset == m_off, "R10 collide offset", longint'(offset), m_off);

    for (int i = 0; i < 40; i++) begin
      run_cal(int'($urandom_range(3)), ($urandom_range(7) == 0),
              int'($urandom_range(1023)), int'($urandom_range(1023)),
              int'($urandom_range(1023)), int'($urandom_range(1023)),
              int'($urandom_range(7)), "R3 random cal R4");
      for (int j = 0; j < 6; j++) begin
        if ($urandom_range(1) == 1)
          run_conv(1, 0, int'($urandom_range(511)) - 256, "R7 random d2c");
        else
          run_conv(0, int'($urandom_range(1023)), 0, "R6 random c2d");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule